// File: doc/BRIEF.md
# Configurable Synchronous Serial Shifter

This block is a byte-wide synchronous serial engine that sends and receives at the same time. A single 8-bit control register sets three things: the idle level of the serial clock (polarity), the edge on which data changes or is captured (phase), and the clock source. A pulse on `start` loads a parallel byte. The block then shifts it out most significant bit first on `sdo` and builds the received byte from `sdi`. When the last bit has been shifted, `busy` drops and `done` pulses for one cycle with the received byte on `rx_byte`.

Clock-select codes 0 to 6 make the block the master. In master mode it drives the serial clock at the system clock divided by 2, 4, up to 128. Code 7 makes it a slave. In slave mode it stops driving the clock pin and shifts on an external clock. That clock is brought into the system domain through a synchroniser, so it must run no faster than a quarter of the system clock. The serial clock must stay at or below 5 MHz, and a 10 MHz system clock with the /2 setting meets this limit exactly.

Top module: `sser_engine`

## Requirements
- R1: After reset the control register reads 0x00, `busy` and `done` are 0, `sck_out` is 1 and `sck_oe` is 1.
- R2: Control register bit 4 is polarity, bit 3 is phase and bits 2..0 are the clock-select code; bits 7..5 ignore writes and read as 0.
- R3: With code c in 0..6, `sck_oe` is 1 and `sck_out` toggles every 2^c system cycles. The first toggle comes 2^c cycles after the cycle that accepts `start`, and a transfer makes exactly 16 toggles.
- R4: The serial clock idles high when polarity is 0 and low when polarity is 1. The first edge of every bit period (the leading edge) moves away from the idle level.
- R5: With phase 0, `sdo` shows bit 7 from the cycle after `start` is accepted. `sdi` is captured on each leading edge, and `sdo` moves to the next bit on each trailing edge.
- R6: With phase 1, `sdo` takes the next bit on each leading edge, so bit 7 appears at the first leading edge and bit 6 at the second. `sdi` is captured on each trailing edge.
- R7: Eight bits move per transfer, bit 7 first down to bit 0. With `sdo` looped back to `sdi`, `rx_byte` equals the sent byte.
- R8: Code 7 selects slave mode. `sck_oe` is 0, and the block shifts on the edges of `sck_in` after a two-stage synchroniser, with the same phase rules as master mode.
- R9: `start` while idle sets `busy` on the next cycle. In the cycle after the final edge, `busy` is 0, `done` is 1 for exactly one cycle, and `rx_byte` holds the received byte. In master mode, `done` comes 16*2^c cycles after the accepting cycle.
- R10: A control-register write while `busy` is 1 leaves the register unchanged.
- R11: A `start` pulse while `busy` is 1 neither restarts nor changes the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| start | input | 1 | Transfer start strobe |
| tx_byte | input | 8 | Byte to send, loaded at start |
| rx_byte | output | 8 | Last received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable (1 in master mode) |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bound checker runs on every cycle. It checks that `done` is a lone one-cycle pulse that follows `busy` and never overlaps it, and that `start` while idle always raises `busy`. It also checks that the register holds through every busy cycle, that the clock pin is released whenever code 7 is selected, and that the master clock rests at the level set by polarity while idle. The bench scenarios are the only place where the clock period and edge count for each divider code are measured. They also show on which edge each phase setting changes `sdo`, that bytes survive the loopback, that slave shifting follows external edges, and that a start or register write in mid-transfer is ignored.

// File: rtl/sser_pkg.sv
package sser_pkg;
   localparam int CSEL_W = 3;
   localparam int CFG_W  = CSEL_W + 2;
   localparam logic [CSEL_W-1:0] CSEL_SLAVE = '1;

   typedef struct packed {
      logic              pol;
      logic              pha;
      logic [CSEL_W-1:0] csel;
   } sser_cfg_t;
endpackage

// File: rtl/sser_ctrl_reg.sv
module sser_ctrl_reg
   import sser_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   input  logic             lock,
   output sser_cfg_t        cfg,
   output logic [REG_W-1:0] rdata
);
   localparam int PAD_W = REG_W - CFG_W;

   sser_cfg_t cfg_q;
   logic      unused_hi;

   assign unused_hi = ^wdata[REG_W-1:CFG_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (we && !lock)
         cfg_q <= sser_cfg_t'(wdata[CFG_W-1:0]);
   end

   assign cfg   = cfg_q;
   assign rdata = {{PAD_W{1'b0}}, cfg_q};
endmodule

// File: rtl/sser_clkgen.sv
module sser_clkgen
   import sser_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              pol,
   input  logic [CSEL_W-1:0] csel,
   input  logic              sck_in,
   output logic              edge_ev,
   output logic              sck_out,
   output logic              sck_oe
);
   localparam int DIV_W = (1 << CSEL_W) - 1;

   logic                   slave;
   logic [DIV_W-1:0]       half_m1;
   logic [DIV_W-1:0]       cnt_q;
   logic                   m_edge;
   logic                   sck_q;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   ext_edge;

   assign slave   = (csel == CSEL_SLAVE);
   assign half_m1 = (DIV_W'(1) << csel) - DIV_W'(1);
   assign m_edge  = run && !slave && (cnt_q == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || m_edge)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + DIV_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sck_q <= 1'b1;
      else if (!run)
         sck_q <= ~pol;
      else if (m_edge)
         sck_q <= ~sck_q;
   end

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= sck_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign ext_edge = sync_q[SYNC_STAGES-1] ^ prev_q;
   assign edge_ev  = slave ? (run && ext_edge) : m_edge;
   assign sck_out  = sck_q;
   assign sck_oe   = !slave;
endmodule

// File: rtl/sser_shifter.sv
module sser_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              edge_ev,
   input  logic              pha,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              sdi,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              sdo
);
   localparam int EDGE_W = $clog2(2 * DATA_W);
   localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(2 * DATA_W - 1);

   logic [DATA_W-1:0] shreg_q;
   logic [DATA_W-1:0] shreg_nxt;
   logic [EDGE_W-1:0] ecnt_q;
   logic              samp_q;
   logic              dout_q;
   logic              busy_q;
   logic              done_q;
   logic [DATA_W-1:0] rx_q;
   logic              leading;
   logic              accept;

   assign accept    = start && !busy_q;
   assign leading   = !ecnt_q[0];
   assign shreg_nxt = {shreg_q[DATA_W-2:0], (pha ? sdi : samp_q)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         ecnt_q  <= '0;
         samp_q  <= 1'b0;
         dout_q  <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         rx_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            shreg_q <= tx_byte;
            ecnt_q  <= '0;
            busy_q  <= 1'b1;
         end else if (busy_q && edge_ev) begin
            ecnt_q <= ecnt_q + EDGE_W'(1);
            if (leading) begin
               if (pha) dout_q <= shreg_q[DATA_W-1];
               else     samp_q <= sdi;
            end else begin
               shreg_q <= shreg_nxt;
               if (ecnt_q == EDGE_LAST) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  rx_q   <= shreg_nxt;
               end
            end
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign rx_byte = rx_q;
   assign sdo     = pha ? dout_q : shreg_q[DATA_W-1];
endmodule

// File: rtl/sser_engine.sv
module sser_engine
   import sser_pkg::*;
#(
   parameter int REG_W       = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output logic              busy,
   output logic              done,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   output logic              sdo,
   input  logic              sdi
);
   if (REG_W <= CFG_W) begin : g_bad_reg
      $error("REG_W must exceed the configuration field width");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   sser_cfg_t cfg;
   logic      edge_ev;

   sser_ctrl_reg #(.REG_W(REG_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .lock  (busy),
      .cfg   (cfg),
      .rdata (cfg_rdata)
   );

   sser_clkgen #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .pol     (cfg.pol),
      .csel    (cfg.csel),
      .sck_in  (sck_in),
      .edge_ev (edge_ev),
      .sck_out (sck_out),
      .sck_oe  (sck_oe)
   );

   sser_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .edge_ev (edge_ev),
      .pha     (cfg.pha),
      .tx_byte (tx_byte),
      .sdi     (sdi),
      .busy    (busy),
      .done    (done),
      .rx_byte (rx_byte),
      .sdo     (sdo)
   );
endmodule

// File: rtl/sser_engine_chk.sv
module sser_engine_chk #(
   parameter int REG_W  = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [REG_W-1:0]  cfg_wdata,
   input logic [REG_W-1:0]  cfg_rdata,
   input logic              start,
   input logic [DATA_W-1:0] tx_byte,
   input logic [DATA_W-1:0] rx_byte,
   input logic              busy,
   input logic              done,
   input logic              sck_in,
   input logic              sck_out,
   input logic              sck_oe,
   input logic              sdo,
   input logic              sdi
);
   p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cfg_rdata));

   p_slave_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[2:0] == 3'b111) |-> !sck_oe);

   p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy) && $stable(cfg_rdata) && cfg_rdata[2:0] != 3'b111)
         |-> (sck_out == !cfg_rdata[4]));
endmodule

bind sser_engine sser_engine_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sser_engine_bench.sv
module sser_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // each entry: control byte in [15:8], data byte in [7:0]
   localparam logic [15:0] VEC [NVEC] = '{
      16'h00A5, 16'h093C, 16'h12C3, 16'h1B81,
      16'h047E, 16'h0D01, 16'h16FF, 16'h185A
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_we;
   logic [7:0] cfg_wdata;
   logic [7:0] cfg_rdata;
   logic       start;
   logic [7:0] tx_byte;
   logic [7:0] rx_byte;
   logic       busy;
   logic       done;
   logic       sck_in;
   logic       sck_out;
   logic       sck_oe;
   logic       sdo;
   logic       sdi;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;
   assign sdi = sdo;

   sser_engine u_sser_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .start(start), .tx_byte(tx_byte),
      .rx_byte(rx_byte), .busy(busy), .done(done), .sck_in(sck_in),
      .sck_out(sck_out), .sck_oe(sck_oe), .sdo(sdo), .sdi(sdi)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_master(input logic [7:0] cfg, input logic [7:0] tx, input bit poke);
      int h;
      int trans;
      int first;
      int last;
      int dur;
      int dcnt;
      logic idle;
      logic prev;
      h = 1 << cfg[2:0];
      idle = ~cfg[4];
      wr_cfg(cfg);
      @(negedge clk);
      chk(sck_out == idle, "R4 idle level", sck_out, idle);
      chk(sck_oe == 1'b1, "R3 master drives clock", sck_oe, 1);
      tx_byte = tx;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 busy after start", busy, 1);
      prev = sck_out;
      trans = 0; first = -1; last = -1; dur = -1; dcnt = 0;
      for (int n = 1; n <= 16 * h + 4; n++) begin
         @(negedge clk);
         if (poke && n == 3) begin tx_byte = ~tx; start = 1'b1; end
         if (poke && n == 4) start = 1'b0;
         if (poke && n == 5) begin cfg_we = 1'b1; cfg_wdata = cfg ^ 8'h1F; end
         if (poke && n == 6) cfg_we = 1'b0;
         if (sck_out != prev) begin
            trans++;
            last = n;
            if (first < 0) begin
               first = n;
               chk(sck_out != idle, "R4 leading edge leaves idle", sck_out, ~idle);
            end
         end
         prev = sck_out;
         if (done) begin
            dcnt++;
            if (dur < 0) dur = n;
            chk(rx_byte == tx, "R7 loopback byte", rx_byte, tx);
         end
         if (!cfg[3]) begin
            if (n == 1)     chk(sdo == tx[7], "R5 bit7 before first edge", sdo, tx[7]);
            if (n == 2 * h) chk(sdo == tx[6], "R5 bit6 after trailing edge", sdo, tx[6]);
         end else begin
            if (n == h)     chk(sdo == tx[7], "R6 bit7 on leading edge", sdo, tx[7]);
            if (n == 3 * h) chk(sdo == tx[6], "R6 bit6 on second leading edge", sdo, tx[6]);
         end
      end
      chk(first == h, "R3 first toggle delay", first, h);
      chk(trans == 16, "R3 toggle count", trans, 16);
      chk(last == 16 * h, "R3 clock period", last, 16 * h);
      chk(dur == 16 * h, "R9 done timing", dur, 16 * h);
      chk(dcnt == 1, "R9 single done pulse", dcnt, 1);
      chk(busy == 1'b0, "R9 busy cleared", busy, 0);
      if (poke) begin
         chk(cfg_rdata == cfg, "R10 write during busy ignored", cfg_rdata, cfg);
         chk(rx_byte == tx, "R11 start during busy ignored", rx_byte, tx);
      end
   endtask

   task automatic run_slave(input logic [7:0] cfg, input logic [7:0] tx);
      int dcnt;
      logic [7:0] got;
      sck_in = ~cfg[4];
      wr_cfg(cfg);
      repeat (4) @(negedge clk);
      chk(sck_oe == 1'b0, "R8 clock pin released", sck_oe, 0);
      tx_byte = tx;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      dcnt = 0;
      got = '0;
      for (int k = 0; k < 16; k++) begin
         repeat (4) begin
            @(negedge clk);
            if (done) begin dcnt++; got = rx_byte; end
         end
         sck_in = ~sck_in;
      end
      repeat (10) begin
         @(negedge clk);
         if (done) begin dcnt++; got = rx_byte; end
      end
      chk(dcnt == 1, "R8 slave transfer completes", dcnt, 1);
      chk(got == tx, "R8 slave loopback byte", got, tx);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cfg_we = 1'b0;
      cfg_wdata = '0;
      start = 1'b0;
      tx_byte = '0;
      sck_in = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cfg_rdata == 8'h00, "R1 register reset", cfg_rdata, 0);
      chk(busy == 1'b0, "R1 busy reset", busy, 0);
      chk(done == 1'b0, "R1 done reset", done, 0);
      chk(sck_out == 1'b1, "R1 clock idle high", sck_out, 1);
      chk(sck_oe == 1'b1, "R1 master after reset", sck_oe, 1);

      // R2 field layout and zero upper bits
      wr_cfg(8'hFF);
      chk(cfg_rdata == 8'h1F, "R2 upper bits read zero", cfg_rdata, 8'h1F);
      wr_cfg(8'hE9);
      chk(cfg_rdata == 8'h09, "R2 field readback", cfg_rdata, 8'h09);

      // table walk: every timing type and every master code
      for (int i = 0; i < NVEC; i++)
         run_master(VEC[i][15:8], VEC[i][7:0], 1'b0);

      // R10 and R11: write and start during a transfer
      run_master(8'h0A, 8'h96, 1'b1);
      run_master(8'h11, 8'h4B, 1'b1);

      // R8 slave mode under two timing types
      run_slave(8'h17, 8'hC6);
      run_slave(8'h0F, 8'h39);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule